// File: doc/BRIEF.md
# Dual-Channel ADC Offset Calibrator

This block sits behind a pair of 10-bit converter cores, an in-phase (I) channel and a quadrature (Q) channel, and removes the DC offset of each. Conversions arrive as straight binary, with code 512 standing for zero differential input. A rising edge on the calibrate request starts a sequence of fixed length. During that sequence both inputs are expected to sit at zero differential input. The block sums 32 conversions from each channel, relative to midscale, and divides the sum by 32. It keeps the result as that channel's offset. From then on it subtracts the stored offset from every sample of that channel and clamps the result to the legal code range.

The sequence is driven by a four-state machine. ST_IDLE waits for a request edge. IDLE_TO_FILL is taken on a rising edge of `cal_req`. ST_FILL lasts one cycle: it clears the accumulators and registers the first window sample, then FILL_TO_ACCUM follows. ST_ACCUM lasts 32 cycles and adds one registered sample per channel on each of them. ACCUM_TO_LATCH is taken after the 32nd addition. ST_LATCH lasts one cycle: it shifts each sum right by five and stores the result as the new offset. LATCH_TO_IDLE then returns the machine to ST_IDLE. While the machine is out of ST_IDLE it reports busy and ignores any new request edge.

Top module: `adc_offset_cal`

## Requirements
- R1: A sequence starts only when `cal_req` is sampled high on a clock edge after it was sampled low on the edge before. Holding `cal_req` high does not start a second sequence.
- R2: `cal_busy` goes high on the clock edge after the request edge and stays high for exactly 34 clock cycles.
- R3: The averaging window is the 32 samples of each channel presented on the first 32 clock edges at which `cal_busy` is already high. Each sample is taken as (raw − 512).
- R4: The I and Q channels each compute and store their own offset. A calibration gives each channel only the offset derived from its own samples.
- R5: Every corrected output equals its raw input of the previous clock edge minus the stored offset. A new offset takes effect on the clock edge after the one at which `cal_busy` falls.
- R6: Raw and corrected buses are 10-bit straight binary, with 512 standing for zero input.
- R7: A corrected value below 0 is output as 0, and a corrected value above 1023 is output as 1023.
- R8: Rising edges of `cal_req` that arrive while `cal_busy` is high are ignored. They neither restart nor lengthen the sequence.
- R9: After reset both offsets are zero, so samples pass through unchanged, and `cal_busy` is low.
- R10: The offset is the sum divided by 32 with rounding toward minus infinity. For example, a sum of −33 gives −2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_req | input | 1 | Calibration request; its rising edge starts a sequence |
| raw_i | input | 10 | I-channel conversion, straight binary |
| raw_q | input | 10 | Q-channel conversion, straight binary |
| corr_i | output | 10 | Offset-corrected I sample, saturated |
| corr_q | output | 10 | Offset-corrected Q sample, saturated |
| cal_busy | output | 1 | High while a calibration sequence runs |

## Verification
The hardest case to reach is a window whose boundary or rounding matters. Here a one-cycle misalignment of the 32-sample window, or a truncating divide, changes the stored offset by one code. The stimulus therefore drives a distinct value on every cycle around a calibration, with values just outside the window far from midscale. It also builds one window whose Q sum is exactly −33, where flooring and truncation disagree. Request edges are also toggled inside a running sequence, and the request is held high across its end, so that any restart or extension shows up on `cal_busy` and in the later corrected outputs.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_ACCUM = 2'd2,
        ST_LATCH = 2'd3
    } cal_state_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import adc_cal_pkg::*;
#(
    parameter int ACC_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_req,
    output logic busy,
    output logic clr_acc,
    output logic acc_en,
    output logic load_off
);

    localparam int CNT_W = $clog2(ACC_CYCLES) + 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACC_CYCLES - 1);

    cal_state_e       state_q;
    cal_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             req_d;
    logic             req_edge;

    assign req_edge = cal_req & ~req_d;

    // state register, request history and window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_d   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            req_d   <= cal_req;
            if (state_q == ST_ACCUM) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_edge) state_d = ST_FILL;        // IDLE_TO_FILL
            ST_FILL:  state_d = ST_ACCUM;                     // FILL_TO_ACCUM
            ST_ACCUM: if (cnt_q == LAST_CNT) state_d = ST_LATCH; // ACCUM_TO_LATCH
            ST_LATCH: state_d = ST_IDLE;                      // LATCH_TO_IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        clr_acc  = 1'b0;
        acc_en   = 1'b0;
        load_off = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy     = 1'b0;
            ST_FILL:  clr_acc  = 1'b1;
            ST_ACCUM: acc_en   = 1'b1;
            ST_LATCH: load_off = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

endmodule

// File: rtl/offset_channel.sv
module offset_channel #(
    parameter int DATA_W   = 10,
    parameter int AVG_LOG2 = 5,
    parameter int ACC_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw,
    input  logic              clr_acc,
    input  logic              acc_en,
    input  logic              load_off,
    output logic [DATA_W-1:0] corr
);

    localparam logic [DATA_W:0] MID_CODE = (DATA_W+1)'(1) << (DATA_W - 1);
    localparam int              MAX_CODE = (1 << DATA_W) - 1;
    localparam int              DIFF_W   = DATA_W + 2;

    logic        [DATA_W-1:0] samp_q;
    logic signed [DATA_W:0]   centred;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  avg;
    logic signed [DATA_W:0]   offset_q;
    logic signed [DIFF_W-1:0] diff;
    logic        [DATA_W-1:0] clamped;

    assign centred = $signed({1'b0, samp_q}) - $signed(MID_CODE);
    assign avg     = acc_q >>> AVG_LOG2;
    assign diff    = $signed({2'b00, raw}) - DIFF_W'(offset_q);

    always_comb begin
        if (diff < 0) begin
            clamped = '0;
        end else if (diff > MAX_CODE) begin
            clamped = '1;
        end else begin
            clamped = diff[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q   <= '0;
            acc_q    <= '0;
            offset_q <= '0;
            corr     <= '0;
        end else begin
            samp_q <= raw;
            corr   <= clamped;
            if (clr_acc) begin
                acc_q <= '0;
            end else if (acc_en) begin
                acc_q <= acc_q + ACC_W'(centred);
            end
            if (load_off) begin
                offset_q <= avg[DATA_W:0];
            end
        end
    end

endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
    import adc_cal_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int AVG_LOG2   = 5,
    parameter int ACC_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_req,
    input  logic [DATA_W-1:0] raw_i,
    input  logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] corr_i,
    output logic [DATA_W-1:0] corr_q,
    output logic              cal_busy
);

    localparam int ACC_CYCLES = 1 << AVG_LOG2;

    logic                clr_acc;
    logic                acc_en;
    logic                load_off;
    logic [DATA_W-1:0]   raw_arr  [NUM_CH];
    logic [DATA_W-1:0]   corr_arr [NUM_CH];

    assign raw_arr[0] = raw_i;
    assign raw_arr[1] = raw_q;
    assign corr_i     = corr_arr[0];
    assign corr_q     = corr_arr[1];

    cal_sequencer #(
        .ACC_CYCLES (ACC_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_req  (cal_req),
        .busy     (cal_busy),
        .clr_acc  (clr_acc),
        .acc_en   (acc_en),
        .load_off (load_off)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        offset_channel #(
            .DATA_W   (DATA_W),
            .AVG_LOG2 (AVG_LOG2),
            .ACC_W    (ACC_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (raw_arr[ch]),
            .clr_acc  (clr_acc),
            .acc_en   (acc_en),
            .load_off (load_off),
            .corr     (corr_arr[ch])
        );
    end

endmodule

// File: rtl/adc_offset_cal_chk.sv
module adc_offset_cal_chk (
    input logic clk,
    input logic rst_n,
    input logic cal_req,
    input logic cal_busy
);

    localparam int SEQ_LEN = 34;

    logic       req_seen;
    logic [7:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen <= 1'b0;
            run_cnt  <= '0;
        end else begin
            req_seen <= cal_req;
            if (cal_busy) begin
                if (run_cnt != 8'hFF) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end
    end

    AST_EDGE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy && cal_req && !req_seen) |=> cal_busy); // R1

    AST_NO_LEVEL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_busy && !(cal_req && !req_seen)) |=> !cal_busy); // R1

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> (run_cnt == 8'(SEQ_LEN))); // R2

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (run_cnt < 8'(SEQ_LEN))); // R8

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && run_cnt < 8'(SEQ_LEN - 1)) |=> cal_busy); // R8

endmodule

bind adc_offset_cal adc_offset_cal_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_req  (cal_req),
    .cal_busy (cal_busy)
);

// File: tb/test_adc_offset_cal.sv
module test_adc_offset_cal;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_req = 1'b0;
    logic [9:0] raw_i = 10'd0;
    logic [9:0] raw_q = 10'd0;
    logic [9:0] corr_i;
    logic [9:0] corr_q;
    logic       cal_busy;

    int    n_chk = 0;
    int    n_err = 0;
    string tag = "R9";

    // reference model state
    int m_cnt, m_sum_i, m_sum_q, m_off_i, m_off_q;
    int e_i, e_q;
    bit e_busy, m_req_d;

    always #5 clk = ~clk;

    adc_offset_cal i_adc_offset_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_req  (cal_req),
        .raw_i    (raw_i),
        .raw_q    (raw_q),
        .corr_i   (corr_i),
        .corr_q   (corr_q),
        .cal_busy (cal_busy)
    );

    function automatic int sat(int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sum_i = 0; m_sum_q = 0; m_off_i = 0; m_off_q = 0;
            e_i = 0; e_q = 0; e_busy = 0; m_req_d = 0;
        end else begin
            e_i = sat(int'(raw_i) - m_off_i);
            e_q = sat(int'(raw_q) - m_off_q);
            if (m_cnt > 0) begin
                if (35 - m_cnt <= 32) begin
                    m_sum_i += int'(raw_i) - 512;
                    m_sum_q += int'(raw_q) - 512;
                end
                if (35 - m_cnt == 34) begin
                    m_off_i = m_sum_i >>> 5;
                    m_off_q = m_sum_q >>> 5;
                end
                m_cnt--;
            end else if (cal_req && !m_req_d) begin
                m_cnt = 34; m_sum_i = 0; m_sum_q = 0;
            end
            m_req_d = cal_req;
            e_busy  = (m_cnt > 0);
        end
    end

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input int ri, input int rq);
        @(negedge clk);
        check("corr_i", int'(corr_i), e_i);
        check("corr_q", int'(corr_q), e_q);
        check("cal_busy", int'(cal_busy), int'(e_busy));
        cal_req = c;
        raw_i   = 10'(ri);
        raw_q   = 10'(rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R9";
        check("reset corr_i", int'(corr_i), 0);
        check("reset corr_q", int'(corr_q), 0);
        check("reset cal_busy", int'(cal_busy), 0);
        rst_n = 1'b1;
        // R9 / R6: pass-through with zero offsets
        cyc(0, 0, 1023); cyc(0, 1023, 0); cyc(0, 512, 512);
        cyc(0, 77, 900); cyc(0, 301, 14); cyc(0, 0, 0);
        // R1: request held high, one sequence only; I at +8, Q at -12
        tag = "R1";
        for (int n = 0; n < 60; n++) cyc(1, 520, 500);
        for (int n = 0; n < 4; n++) cyc(0, 520, 500);
        // R5: subtraction applied to later samples
        tag = "R5";
        cyc(0, 100, 600); cyc(0, 600, 100); cyc(0, 512, 512); cyc(0, 9, 999);
        // R7: saturation at both ends
        tag = "R7";
        cyc(0, 3, 1020); cyc(0, 0, 1023); cyc(0, 8, 1011); cyc(0, 1023, 1012);
        cyc(0, 7, 1015);
        // R8: extra edges while busy
        tag = "R8";
        cyc(1, 530, 490);
        for (int n = 0; n < 40; n++) cyc((n % 3) == 1, 530 + (n % 5), 490 - (n % 7));
        for (int n = 0; n < 6; n++) cyc(0, 200 + n, 800 - n);
        // R3: window alignment with distinct values, far values outside window
        tag = "R3";
        cyc(0, 900, 100);
        cyc(1, 900, 100);
        for (int n = 0; n < 32; n++) cyc(0, 480 + ((n * 37) % 61), 500 + ((n * 13) % 29));
        for (int n = 0; n < 6; n++) cyc(0, 100, 900);
        for (int n = 0; n < 4; n++) cyc(0, 300 + n, 700 - n);
        // R4: I centred, Q offset alone
        tag = "R4";
        cyc(1, 512, 540);
        for (int n = 0; n < 36; n++) cyc(0, 512, 540);
        cyc(0, 256, 256); cyc(0, 768, 768);
        // R10: Q sum of -33 must floor to -2
        tag = "R10";
        cyc(1, 512, 511);
        cyc(0, 512, 510);
        for (int n = 0; n < 38; n++) cyc(0, 512, 511);
        cyc(0, 100, 100); cyc(0, 1022, 1022); cyc(0, 1, 1);
        cyc(0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule